// File: doc/BRIEF.md
# Packed Four-Product Coefficient Multiplier

This arithmetic unit produces four coefficient products of a polynomial schoolbook multiplier from one wide unsigned multiplication. It takes two neighbouring 13-bit public coefficients `a0`, `a1` and two neighbouring small signed secret coefficients `s0`, `s1`, each in the range -4..4. It returns the two direct products `a0*s0` and `a1*s1`, and the cross sum `a0*s1 + a1*s0`. All three results are reduced modulo 2^13. The enclosing multiplier adds these values into its accumulator. Accumulation, buffering and sequencing are outside this block.

Inside the block, both public coefficients go into one 28-bit operand, with the second coefficient placed 15 bits above the first. The magnitudes of both secret coefficients go into one 18-bit operand with the same spacing. When the two secret signs differ, `a0` is negated (mod 2^13) before packing, so that the cross terms come out as a difference. After the product is split into its fields, the cross field is negated when `s0` is negative, and both direct fields are negated when `s1` is negative.

The wide product is formed as an unsigned 26x17 core multiplication plus two small correction terms. These corrections use only selects, shifts and adds. The highest-order partial term is dropped, because it lies wholly above the bits that are kept. The cross sum can carry one bit into the upper field. That field is repaired by comparing its lowest bit with the parity its true value must have. An optional register stage after the wide sum gives the unit a fixed latency, which is marked by a valid pair.

Top module: `packedCoefMul`

## Requirements
- R1: `prodDirect0` equals `pubA0 * secS0` modulo 2^13. `pubA0` is an unsigned 13-bit value. `secS0` is a 4-bit two's-complement value in -4..4. The result is the low 13 bits of the two's-complement product.
- R2: `prodDirect1` equals `pubA1 * secS1` modulo 2^13, with the same encodings as R1.
- R3: `crossSum` equals `pubA0 * secS1 + pubA1 * secS0` modulo 2^13.
- R4: R1 to R3 hold for every one of the 81 pairs (`secS0`, `secS1`) in -4..4. This covers equal signs, opposite signs and zero values on either side.
- R5: When the cross field reaches 16 bits and spills into the upper field, `prodDirect1` is still exact. The test case is both public coefficients at 8191 with both secret magnitudes at 4, in each sign combination.
- R6: Boundary public values are handled. A zero public coefficient gives zero direct products. 8191 multiplied by -1 gives 1, and 8191 multiplied by -4 gives 4.
- R7: With `PIPE_REG`=1, `outValid` rises exactly one clock edge after the edge that samples `inValid` high, and the results of that input are present at the same time. `outValid` is low in every cycle that does not follow an accepted input.
- R8: With `PIPE_REG`=1, the input values present while `inValid` is low have no effect. The three results keep the values from the last accepted input.
- R9: While `rst_n` is low, and after it is released with no input accepted, `outValid` is 0 and all three results are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | The coefficients on the inputs are to be processed |
| pubA0 | input | 13 | Lower public coefficient, unsigned |
| pubA1 | input | 13 | Upper public coefficient, unsigned |
| secS0 | input | 4 | Lower secret coefficient, two's complement, -4..4 |
| secS1 | input | 4 | Upper secret coefficient, two's complement, -4..4 |
| outValid | output | 1 | Results below belong to an accepted input |
| prodDirect0 | output | 13 | a0*s0 mod 2^13 |
| prodDirect1 | output | 13 | a1*s1 mod 2^13 |
| crossSum | output | 13 | a0*s1 + a1*s0 mod 2^13 |

## Verification
With the default `PIPE_REG`=1, all three results and `outValid` come from the register after the wide sum. They are due at the first rising edge after the one that sampled `inValid` high. The bench changes inputs on the falling edge and reads outputs on the next falling edge, half a cycle after that capturing edge. It also reads `outValid` before the edge, to confirm that nothing appears early. For the hold check, the bench changes the inputs while `inValid` stays low and waits several cycles. It then compares the results against the last accepted set. For `PIPE_REG`=0, the results are due combinationally in the same cycle.

// File: rtl/pcmPkg.sv
package pcmPkg;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // load the product stage
  } pcmStrobe_t;

  // sign steering decided at packing time, applied after unpacking
  typedef struct packed {
    logic negA0;      // a0 negated before packing (signs differ)
    logic negCross;   // cross field negated (s0 negative)
    logic negDirect;  // both direct fields negated (s1 negative)
  } pcmSignPlan_t;

endpackage

// File: rtl/pcmCtrl.sv
module pcmCtrl
  import pcmPkg::*;
#(
  parameter int PIPE_REG = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  output pcmStrobe_t strobe,
  output logic       outValid
);

  assign strobe.capture = inValid;

  generate
    if (PIPE_REG != 0) begin : g_reg
      logic validQ;
      always_ff @(posedge clk) begin
        if (!rst_n) validQ <= 1'b0;
        else        validQ <= inValid;
      end
      assign outValid = validQ;
    end else begin : g_comb
      assign outValid = inValid;
    end
  endgenerate

endmodule

// File: rtl/pcmPacker.sv
module pcmPacker
  import pcmPkg::*;
#(
  parameter int COEF_W = 13,
  parameter int SEC_W  = 4,
  parameter int LANE_W = 15,
  localparam int MAG_W = SEC_W - 1,
  localparam int A_W   = LANE_W + COEF_W,
  localparam int S_W   = LANE_W + MAG_W
) (
  input  logic [COEF_W-1:0]       pubA0,
  input  logic [COEF_W-1:0]       pubA1,
  input  logic signed [SEC_W-1:0] secS0,
  input  logic signed [SEC_W-1:0] secS1,
  output logic [A_W-1:0]          packA,
  output logic [S_W-1:0]          packS,
  output pcmSignPlan_t            plan,
  output logic                    fixBit
);

  logic             sign0, sign1;
  logic [MAG_W-1:0] mag0, mag1;
  logic [COEF_W-1:0] a0Steered;

  assign sign0 = secS0[SEC_W-1];
  assign sign1 = secS1[SEC_W-1];

  // magnitudes: -4 -> 4 fits MAG_W bits
  assign mag0 = sign0 ? MAG_W'(-secS0) : MAG_W'(secS0);
  assign mag1 = sign1 ? MAG_W'(-secS1) : MAG_W'(secS1);

  assign plan.negA0     = sign0 ^ sign1;
  assign plan.negCross  = sign0;
  assign plan.negDirect = sign1;

  assign a0Steered = plan.negA0 ? -pubA0 : pubA0;

  assign packA = (A_W'(pubA1) << LANE_W) | A_W'(a0Steered);
  assign packS = (S_W'(mag1)  << LANE_W) | S_W'(mag0);

  // parity the upper field must carry when no spill happened
  assign fixBit = pubA1[0] & mag1[0];

endmodule

// File: rtl/pcmWideCore.sv
module pcmWideCore #(
  parameter int A_W      = 28,
  parameter int S_W      = 18,
  parameter int CORE_A_W = 26,
  parameter int CORE_B_W = 17,
  parameter int PROD_W   = 43,
  localparam int HI_A_W  = A_W - CORE_A_W,
  localparam int HI_S_W  = S_W - CORE_B_W
) (
  input  logic [A_W-1:0]    packA,
  input  logic [S_W-1:0]    packS,
  output logic [PROD_W-1:0] prod
);

  logic [CORE_A_W-1:0] lowA;
  logic [HI_A_W-1:0]   hiA;
  logic [CORE_B_W-1:0] lowS;
  logic [HI_S_W-1:0]   hiS;

  assign lowA = packA[CORE_A_W-1:0];
  assign hiA  = packA[A_W-1:CORE_A_W];
  assign lowS = packS[CORE_B_W-1:0];
  assign hiS  = packS[S_W-1:CORE_B_W];

  // unsigned core product of the low parts
  logic [PROD_W-1:0] coreProd;
  assign coreProd = PROD_W'(lowA) * PROD_W'(lowS);

  // lowA * hiS via bit selects and shifts
  logic [PROD_W-1:0] accAs [HI_S_W+1];
  assign accAs[0] = '0;
  generate
    for (genvar j = 0; j < HI_S_W; j++) begin : g_as
      assign accAs[j+1] = accAs[j] +
        (hiS[j] ? (PROD_W'(lowA) << (CORE_B_W + j)) : PROD_W'(0));
    end
  endgenerate

  // hiA * lowS via bit selects and shifts (acts as a small select table)
  logic [PROD_W-1:0] accSa [HI_A_W+1];
  assign accSa[0] = '0;
  generate
    for (genvar i = 0; i < HI_A_W; i++) begin : g_sa
      assign accSa[i+1] = accSa[i] +
        (hiA[i] ? (PROD_W'(lowS) << (CORE_A_W + i)) : PROD_W'(0));
    end
  endgenerate

  // hiA * hiS lands at or above bit CORE_A_W+CORE_B_W and is not needed
  assign prod = coreProd + accAs[HI_S_W] + accSa[HI_A_W];

endmodule

// File: rtl/pcmUnpacker.sv
module pcmUnpacker
  import pcmPkg::*;
#(
  parameter int COEF_W = 13,
  parameter int LANE_W = 15,
  localparam int PROD_W = 2 * LANE_W + COEF_W
) (
  input  logic [PROD_W-1:0] prod,
  input  pcmSignPlan_t      plan,
  input  logic              fixBit,
  output logic [COEF_W-1:0] prodDirect0,
  output logic [COEF_W-1:0] prodDirect1,
  output logic [COEF_W-1:0] crossSum
);

  logic [COEF_W-1:0] fieldLo, fieldMid, fieldHiRaw, fieldHi;

  assign fieldLo    = prod[COEF_W-1:0];
  assign fieldMid   = prod[LANE_W +: COEF_W];
  assign fieldHiRaw = prod[2*LANE_W +: COEF_W];

  // gap bits carry field growth but are not results
  logic unusedGap;
  assign unusedGap = ^{prod[LANE_W-1:COEF_W], prod[2*LANE_W-1:LANE_W+COEF_W]};

  // a spilled cross carry flips the low bit away from its true parity
  assign fieldHi = (fieldHiRaw[0] != fixBit) ? fieldHiRaw - COEF_W'(1) : fieldHiRaw;

  assign prodDirect0 = plan.negDirect ? -fieldLo  : fieldLo;
  assign prodDirect1 = plan.negDirect ? -fieldHi  : fieldHi;
  assign crossSum    = plan.negCross  ? -fieldMid : fieldMid;

endmodule

// File: rtl/pcmDatapath.sv
module pcmDatapath
  import pcmPkg::*;
#(
  parameter int COEF_W   = 13,
  parameter int SEC_W    = 4,
  parameter int LANE_W   = 15,
  parameter int CORE_A_W = 26,
  parameter int CORE_B_W = 17,
  parameter int PIPE_REG = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  pcmStrobe_t              strobe,
  input  logic [COEF_W-1:0]       pubA0,
  input  logic [COEF_W-1:0]       pubA1,
  input  logic signed [SEC_W-1:0] secS0,
  input  logic signed [SEC_W-1:0] secS1,
  output logic [COEF_W-1:0]       prodDirect0,
  output logic [COEF_W-1:0]       prodDirect1,
  output logic [COEF_W-1:0]       crossSum
);

  localparam int MAG_W  = SEC_W - 1;
  localparam int A_W    = LANE_W + COEF_W;
  localparam int S_W    = LANE_W + MAG_W;
  localparam int PROD_W = 2 * LANE_W + COEF_W;

  logic [A_W-1:0]    packA;
  logic [S_W-1:0]    packS;
  pcmSignPlan_t      planD, planQ;
  logic              fixD, fixQ;
  logic [PROD_W-1:0] prodD, prodQ;

  pcmPacker #(
    .COEF_W(COEF_W), .SEC_W(SEC_W), .LANE_W(LANE_W)
  ) u_packer (
    .pubA0(pubA0), .pubA1(pubA1), .secS0(secS0), .secS1(secS1),
    .packA(packA), .packS(packS), .plan(planD), .fixBit(fixD)
  );

  pcmWideCore #(
    .A_W(A_W), .S_W(S_W), .CORE_A_W(CORE_A_W), .CORE_B_W(CORE_B_W), .PROD_W(PROD_W)
  ) u_core (
    .packA(packA), .packS(packS), .prod(prodD)
  );

  generate
    if (PIPE_REG != 0) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          prodQ <= '0;
          planQ <= '0;
          fixQ  <= 1'b0;
        end else if (strobe.capture) begin
          prodQ <= prodD;
          planQ <= planD;
          fixQ  <= fixD;
        end
      end
    end else begin : g_pass
      assign prodQ = prodD;
      assign planQ = planD;
      assign fixQ  = fixD;
    end
  endgenerate

  pcmUnpacker #(
    .COEF_W(COEF_W), .LANE_W(LANE_W)
  ) u_unpacker (
    .prod(prodQ), .plan(planQ), .fixBit(fixQ),
    .prodDirect0(prodDirect0), .prodDirect1(prodDirect1), .crossSum(crossSum)
  );

endmodule

// File: rtl/packedCoefMul.sv
module packedCoefMul
  import pcmPkg::*;
#(
  parameter int COEF_W   = 13,
  parameter int SEC_W    = 4,
  parameter int LANE_W   = 15,
  parameter int CORE_A_W = 26,
  parameter int CORE_B_W = 17,
  parameter int PIPE_REG = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inValid,
  input  logic [COEF_W-1:0]       pubA0,
  input  logic [COEF_W-1:0]       pubA1,
  input  logic signed [SEC_W-1:0] secS0,
  input  logic signed [SEC_W-1:0] secS1,
  output logic                    outValid,
  output logic [COEF_W-1:0]       prodDirect0,
  output logic [COEF_W-1:0]       prodDirect1,
  output logic [COEF_W-1:0]       crossSum
);

  pcmStrobe_t strobe;

  pcmCtrl #(.PIPE_REG(PIPE_REG)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  pcmDatapath #(
    .COEF_W(COEF_W), .SEC_W(SEC_W), .LANE_W(LANE_W),
    .CORE_A_W(CORE_A_W), .CORE_B_W(CORE_B_W), .PIPE_REG(PIPE_REG)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .pubA0(pubA0), .pubA1(pubA1), .secS0(secS0), .secS1(secS1),
    .prodDirect0(prodDirect0), .prodDirect1(prodDirect1), .crossSum(crossSum)
  );

endmodule

// File: rtl/pcmChecker.sv
module pcmChecker #(
  parameter int COEF_W   = 13,
  parameter int SEC_W    = 4,
  parameter int PIPE_REG = 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    inValid,
  input logic [COEF_W-1:0]       pubA0,
  input logic [COEF_W-1:0]       pubA1,
  input logic signed [SEC_W-1:0] secS0,
  input logic signed [SEC_W-1:0] secS1,
  input logic                    outValid,
  input logic [COEF_W-1:0]       prodDirect0,
  input logic [COEF_W-1:0]       prodDirect1,
  input logic [COEF_W-1:0]       crossSum
);

  function automatic logic [COEF_W-1:0] modMul(input logic [COEF_W-1:0] a,
                                               input logic signed [SEC_W-1:0] s);
    int p;
    p = int'(a) * int'(s);
    return COEF_W'(p);
  endfunction

  logic [COEF_W-1:0] refD0, refD1, refX;
  assign refD0 = modMul(pubA0, secS0);
  assign refD1 = modMul(pubA1, secS1);
  assign refX  = modMul(pubA0, secS1) + modMul(pubA1, secS0);

  generate
    if (PIPE_REG != 0) begin : g_reg
      logic [COEF_W-1:0] expD0, expD1, expX;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          expD0 <= '0; expD1 <= '0; expX <= '0;
        end else if (inValid) begin
          expD0 <= refD0; expD1 <= refD1; expX <= refX;
        end
      end

      p_direct0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        outValid |-> prodDirect0 == expD0);
      p_direct1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        outValid |-> prodDirect1 == expD1);
      p_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
        outValid |-> crossSum == expX);
      p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inValid |=> outValid);
      p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !inValid |=> !outValid);
      p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !inValid |=> ($stable(prodDirect0) && $stable(prodDirect1) && $stable(crossSum)));
    end else begin : g_comb
      p_direct0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        inValid |-> prodDirect0 == refD0);
      p_direct1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inValid |-> prodDirect1 == refD1);
      p_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inValid |-> crossSum == refX);
    end
  endgenerate

endmodule

bind packedCoefMul pcmChecker #(
  .COEF_W(COEF_W), .SEC_W(SEC_W), .PIPE_REG(PIPE_REG)
) u_pcmChecker (
  .clk(clk), .rst_n(rst_n), .inValid(inValid),
  .pubA0(pubA0), .pubA1(pubA1), .secS0(secS0), .secS1(secS1),
  .outValid(outValid), .prodDirect0(prodDirect0),
  .prodDirect1(prodDirect1), .crossSum(crossSum)
);

// File: tb/packedCoefMul_bench.sv
`timescale 1ns/1ps
module packedCoefMul_bench;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              inValid = 1'b0;
  logic [12:0]       pubA0 = '0, pubA1 = '0;
  logic signed [3:0] secS0 = '0, secS1 = '0;
  logic              outValid;
  logic [12:0]       prodDirect0, prodDirect1, crossSum;

  int testsRun = 0;
  int testsFailed = 0;
  logic [12:0] lastD0, lastD1, lastX;

  always #5 clk = ~clk;

  packedCoefMul #(.PIPE_REG(1)) u_packedCoefMul (
    .clk(clk), .rst_n(rst_n), .inValid(inValid),
    .pubA0(pubA0), .pubA1(pubA1), .secS0(secS0), .secS1(secS1),
    .outValid(outValid), .prodDirect0(prodDirect0),
    .prodDirect1(prodDirect1), .crossSum(crossSum)
  );

  task automatic check(input string what, input logic [12:0] act, input logic [12:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic logic [12:0] modMul(input int a, input int s);
    int p;
    p = a * s;
    return 13'(p);
  endfunction

  // drive at a falling edge, result due one rising edge later
  task automatic applyAndCheck(input logic [12:0] a0, input logic [12:0] a1,
                               input int s0, input int s1, input string tag);
    logic [12:0] e0, e1, ex;
    e0 = modMul(int'(a0), s0);
    e1 = modMul(int'(a1), s1);
    ex = modMul(int'(a0), s1) + modMul(int'(a1), s0);
    pubA0 = a0; pubA1 = a1; secS0 = 4'(s0); secS1 = 4'(s1);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " R7 outValid"}, 13'(outValid), 13'd1);
    check({tag, " R1 direct0"},  prodDirect0, e0);
    check({tag, " R2 direct1"},  prodDirect1, e1);
    check({tag, " R3 cross"},    crossSum, ex);
    lastD0 = e0; lastD1 = e1; lastX = ex;
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R9 outValid in reset", 13'(outValid), 13'd0);
    check("R9 direct0 in reset", prodDirect0, 13'd0);
    check("R9 direct1 in reset", prodDirect1, 13'd0);
    check("R9 cross in reset", crossSum, 13'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 outValid after reset", 13'(outValid), 13'd0);
    check("R9 cross after reset", crossSum, 13'd0);
  endtask

  task automatic testAllSecrets();
    for (int s0 = -4; s0 <= 4; s0++) begin
      for (int s1 = -4; s1 <= 4; s1++) begin
        for (int k = 0; k < 3; k++) begin
          applyAndCheck(13'($urandom_range(0, 8191)), 13'($urandom_range(0, 8191)),
                        s0, s1, "R4 sweep");
        end
      end
    end
  endtask

  task automatic testSpill();
    applyAndCheck(13'd8191, 13'd8191,  4,  4, "R5 spill ++");
    applyAndCheck(13'd8191, 13'd8191, -4, -4, "R5 spill --");
    applyAndCheck(13'd8191, 13'd8191,  4, -4, "R5 spill +-");
    applyAndCheck(13'd8191, 13'd8191, -4,  4, "R5 spill -+");
    applyAndCheck(13'd8191, 13'd8191,  3,  4, "R5 spill odd");
    applyAndCheck(13'd8190, 13'd8191,  4,  3, "R5 spill parity");
  endtask

  task automatic testExtremes();
    applyAndCheck(13'd0, 13'd0, -4, 4, "R6 zero pub");
    check("R6 zero direct0", prodDirect0, 13'd0);
    applyAndCheck(13'd8191, 13'd8191, -1, -1, "R6 max neg1");
    check("R6 8191*-1", prodDirect0, 13'd1);
    applyAndCheck(13'd8191, 13'd0, -4, 0, "R6 max neg4");
    check("R6 8191*-4", prodDirect0, 13'd4);
    applyAndCheck(13'd1, 13'd1, 0, 0, "R6 zero sec");
  endtask

  task automatic testLatency();
    pubA0 = 13'd100; pubA1 = 13'd7; secS0 = 4'sd2; secS1 = -4'sd3;
    inValid = 1'b1;
    #1;
    check("R7 no early valid", 13'(outValid), 13'd0);
    @(negedge clk);
    inValid = 1'b0;
    check("R7 valid after one edge", 13'(outValid), 13'd1);
    check("R7 direct0 with valid", prodDirect0, 13'd200);
    check("R7 cross with valid", crossSum, 13'(-300 + 14));
    @(negedge clk);
    check("R7 valid drops", 13'(outValid), 13'd0);
  endtask

  task automatic testHold();
    applyAndCheck(13'd1234, 13'd4321, 3, -2, "R8 setup");
    pubA0 = 13'd5; pubA1 = 13'd9; secS0 = -4'sd4; secS1 = 4'sd4;
    repeat (3) @(negedge clk);
    check("R8 hold direct0", prodDirect0, lastD0);
    check("R8 hold direct1", prodDirect1, lastD1);
    check("R8 hold cross", crossSum, lastX);
    check("R8 no valid", 13'(outValid), 13'd0);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testLatency();
    testAllSecrets();
    testSpill();
    testExtremes();
    testHold();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog R7: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule